// File: doc/BRIEF.md
# Page-One Hardware Stack Controller

This block owns the 8-bit stack pointer of a small processor and performs all stack memory traffic. The stack lives in one fixed 256-byte page, so every address the block puts on its memory port is the page number above the pointer. A caller issues one command per request cycle: push a byte, pull a byte, push a 16-bit return address, pull a 16-bit return address, load the pointer from the X index register, or copy the pointer into X. Pulled data comes back on a data bus with a one-cycle done strobe.

Pushes write at the pointer and then step it down. Pulls step the pointer up and then read, so a push followed by a pull leaves the pointer and the data as they were. A 16-bit value goes out high byte first, which leaves the low byte at the lower address. It returns low byte first and is reassembled as {high, low}. A status byte is pushed and pulled through the byte commands. The pointer wraps modulo 256 and never leaves the page. While a multi-beat command is in progress the block raises busy and ignores any request.

Top module: `stack_page_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pointer reads 0xFD, and busy, pull_done and x_we are low.
- R2: Every access with mem_we or mem_re high drives mem_addr with 0x01 in its upper 8 bits and a pointer-derived value in its lower 8 bits.
- R3: Byte push (cmd_op 1) writes push_byte at address 0x0100+sp in the request cycle, then decrements sp by one.
- R4: Word push (cmd_op 3) writes push_word[15:8] at 0x0100+sp in the request cycle and push_word[7:0] at the next lower address in the following cycle; sp ends two lower, and busy is high for that one following cycle.
- R5: Byte pull (cmd_op 2) increments sp and reads the new address; two cycles after the request cycle pull_done pulses with the byte in pull_data[7:0] and zero in pull_data[15:8].
- R6: Word pull (cmd_op 4) reads sp+1 as the low byte and sp+2 as the high byte; sp ends two higher, busy is high for the two cycles after the request cycle, and three cycles after the request pull_done pulses with pull_data = {high, low}.
- R7: Pointer load (cmd_op 5) copies x_in into sp, visible in the next cycle.
- R8: Pointer read (cmd_op 6) presents sp on x_out with a one-cycle x_we pulse in the next cycle, with flag_n equal to bit 7 and flag_z high exactly when the value is zero.
- R9: The pointer wraps modulo 256 in both directions, and accesses stay in page 0x01 across the wrap.
- R10: A request (any cmd_op) presented while busy is high is ignored: it changes neither sp, memory, x_out nor x_we. Code 0 and code 7 are no-operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request strobe, one cycle per command |
| cmd_op | input | 3 | Command code (0 none, 1 byte push, 2 byte pull, 3 word push, 4 word pull, 5 load pointer, 6 read pointer) |
| push_byte | input | 8 | Byte to push, including a status byte |
| push_word | input | 16 | Return address to push |
| x_in | input | 8 | X register value for pointer load |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_we | output | 1 | Stack memory write enable |
| mem_re | output | 1 | Stack memory read enable; data is returned in the next cycle |
| mem_rdata | input | 8 | Stack memory read data |
| pull_data | output | 16 | Pulled value, valid with pull_done |
| pull_done | output | 1 | One-cycle strobe marking a finished pull |
| busy | output | 1 | Multi-beat command in progress |
| sp | output | 8 | Current stack pointer |
| x_out | output | 8 | Pointer copy for the X register |
| x_we | output | 1 | One-cycle X write strobe |
| flag_n | output | 1 | Negative flag of the copied value |
| flag_z | output | 1 | Zero flag of the copied value |

## Verification
The bench builds the block with its defaults: 8-bit pointer, 16-bit address, page 1 and a reset pointer of 0xFD. Because the pointer can be loaded from X, both wrap directions are reachable in a handful of cycles. Loading 0x01 and then pushing a word crosses the bottom of the page. Loading 0xFF and then pulling crosses the top, and a word push at 0x00 splits its two bytes across the wrap. The bench's synchronous memory model has one-cycle read latency. It fixes the exact cycle of each done strobe and the busy window of each word command, and the bench checks those cycles directly.

// File: rtl/stack_page_pkg.sv
package stack_page_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PUSH_B = 3'd1,
    OP_PULL_B = 3'd2,
    OP_PUSH_W = 3'd3,
    OP_PULL_W = 3'd4,
    OP_SP_LD  = 3'd5,
    OP_SP_RD  = 3'd6,
    OP_SPARE  = 3'd7
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PUSH_LO  = 3'd1,
    ST_PULL_LO  = 3'd2,
    ST_PULL_HI  = 3'd3,
    ST_PULL_ONE = 3'd4
  } stk_state_e;

endpackage

// File: rtl/stack_ptr_reg.sv
module stack_ptr_reg #(
  parameter int unsigned PTR_W    = 8,
  parameter int unsigned RESET_SP = 8'hFD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] ptr_up
);

  localparam logic [PTR_W-1:0] RST_VAL = PTR_W'(RESET_SP);

  // pointer arithmetic wraps modulo 2**PTR_W by width
  function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] step_down(input logic [PTR_W-1:0] p);
    return p - 1'b1;
  endfunction

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= RST_VAL;
    else if (load)   ptr_q <= load_val;
    else if (inc)    ptr_q <= step_up(ptr_q);
    else if (dec)    ptr_q <= step_down(ptr_q);
  end

  assign ptr    = ptr_q;
  assign ptr_up = step_up(ptr_q);

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_page_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [BYTE_W-1:0]   push_byte,
  input  logic [2*BYTE_W-1:0] push_word,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                wr_en,
  output logic                rd_en,
  output logic [BYTE_W-1:0]   wdata,
  output logic                ptr_inc,
  output logic                ptr_dec,
  output logic                ptr_load,
  output logic                xfer_req,
  output logic                accept,
  output logic                busy,
  output logic                done,
  output logic [2*BYTE_W-1:0] pull_data
);

  localparam int unsigned WORD_W = 2 * BYTE_W;

  function automatic logic [WORD_W-1:0] join_le(input logic [BYTE_W-1:0] lo,
                                                input logic [BYTE_W-1:0] hi);
    return {hi, lo};
  endfunction

  stk_state_e st, nxt;
  stk_op_e    op;
  logic [BYTE_W-1:0] lo_q;
  logic              lo_cap_push;
  logic              lo_cap_pull;
  logic              fin;
  logic [WORD_W-1:0] fin_data;

  assign op     = stk_op_e'(cmd_op);
  assign accept = cmd_valid && (st == ST_IDLE);
  assign busy   = (st != ST_IDLE);

  always_comb begin
    nxt         = st;
    wr_en       = 1'b0;
    rd_en       = 1'b0;
    wdata       = '0;
    ptr_inc     = 1'b0;
    ptr_dec     = 1'b0;
    ptr_load    = 1'b0;
    xfer_req    = 1'b0;
    lo_cap_push = 1'b0;
    lo_cap_pull = 1'b0;
    fin         = 1'b0;
    fin_data    = '0;
    case (st)
      ST_IDLE: begin
        if (accept) begin
          case (op)
            OP_PUSH_B: begin
              wr_en   = 1'b1;
              wdata   = push_byte;
              ptr_dec = 1'b1;
            end
            OP_PUSH_W: begin
              wr_en       = 1'b1;
              wdata       = push_word[WORD_W-1:BYTE_W];
              ptr_dec     = 1'b1;
              lo_cap_push = 1'b1;
              nxt         = ST_PUSH_LO;
            end
            OP_PULL_B: begin
              rd_en   = 1'b1;
              ptr_inc = 1'b1;
              nxt     = ST_PULL_ONE;
            end
            OP_PULL_W: begin
              rd_en   = 1'b1;
              ptr_inc = 1'b1;
              nxt     = ST_PULL_LO;
            end
            OP_SP_LD: ptr_load = 1'b1;
            OP_SP_RD: xfer_req = 1'b1;
            default: ;
          endcase
        end
      end
      ST_PUSH_LO: begin
        wr_en   = 1'b1;
        wdata   = lo_q;
        ptr_dec = 1'b1;
        nxt     = ST_IDLE;
      end
      ST_PULL_LO: begin
        lo_cap_pull = 1'b1;
        rd_en       = 1'b1;
        ptr_inc     = 1'b1;
        nxt         = ST_PULL_HI;
      end
      ST_PULL_HI: begin
        fin      = 1'b1;
        fin_data = join_le(lo_q, mem_rdata);
        nxt      = ST_IDLE;
      end
      ST_PULL_ONE: begin
        fin      = 1'b1;
        fin_data = join_le(mem_rdata, '0);
        nxt      = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      lo_q      <= '0;
      done      <= 1'b0;
      pull_data <= '0;
    end else begin
      st   <= nxt;
      done <= fin;
      if (fin)         pull_data <= fin_data;
      if (lo_cap_push) lo_q <= push_word[BYTE_W-1:0];
      else if (lo_cap_pull) lo_q <= mem_rdata;
    end
  end

endmodule

// File: rtl/stack_xfer.sv
module stack_xfer #(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] x_out,
  output logic             x_we,
  output logic             flag_n,
  output logic             flag_z
);

  function automatic logic is_zero(input logic [PTR_W-1:0] v);
    return (v == '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_out  <= '0;
      x_we   <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      x_we <= req;
      if (req) begin
        x_out  <= ptr;
        flag_n <= ptr[PTR_W-1];
        flag_z <= is_zero(ptr);
      end
    end
  end

endmodule

// File: rtl/stack_page_ctrl.sv
module stack_page_ctrl #(
  parameter int unsigned PTR_W    = 8,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PAGE     = 1,
  parameter int unsigned RESET_SP = 8'hFD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [BYTE_W-1:0]   push_byte,
  input  logic [2*BYTE_W-1:0] push_word,
  input  logic [PTR_W-1:0]    x_in,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [2*BYTE_W-1:0] pull_data,
  output logic                pull_done,
  output logic                busy,
  output logic [PTR_W-1:0]    sp,
  output logic [PTR_W-1:0]    x_out,
  output logic                x_we,
  output logic                flag_n,
  output logic                flag_z
);

  localparam int unsigned PAGE_W = ADDR_W - PTR_W;
  localparam logic [PAGE_W-1:0] PAGE_BITS = PAGE_W'(PAGE);

  // named internal events, observed by the bound checker
  logic             ev_accept;
  logic             ev_ptr_inc;
  logic             ev_ptr_dec;
  logic             ev_ptr_load;
  logic             ev_xfer;
  logic [PTR_W-1:0] ptr_up;
  logic [PTR_W-1:0] beat_ptr;

  // writes land at the pointer, reads at the pointer plus one
  function automatic logic [ADDR_W-1:0] page_addr(input logic [PTR_W-1:0] p);
    return {PAGE_BITS, p};
  endfunction

  stack_ptr_reg #(
    .PTR_W   (PTR_W),
    .RESET_SP(RESET_SP)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (ev_ptr_inc),
    .dec     (ev_ptr_dec),
    .load    (ev_ptr_load),
    .load_val(x_in),
    .ptr     (sp),
    .ptr_up  (ptr_up)
  );

  stack_seq #(
    .BYTE_W(BYTE_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .push_byte(push_byte),
    .push_word(push_word),
    .mem_rdata(mem_rdata),
    .wr_en    (mem_we),
    .rd_en    (mem_re),
    .wdata    (mem_wdata),
    .ptr_inc  (ev_ptr_inc),
    .ptr_dec  (ev_ptr_dec),
    .ptr_load (ev_ptr_load),
    .xfer_req (ev_xfer),
    .accept   (ev_accept),
    .busy     (busy),
    .done     (pull_done),
    .pull_data(pull_data)
  );

  stack_xfer #(
    .PTR_W(PTR_W)
  ) u_xfer (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (ev_xfer),
    .ptr   (sp),
    .x_out (x_out),
    .x_we  (x_we),
    .flag_n(flag_n),
    .flag_z(flag_z)
  );

  assign beat_ptr = mem_re ? ptr_up : sp;
  assign mem_addr = page_addr(beat_ptr);

endmodule

// File: rtl/stack_page_ctrl_chk.sv
module stack_page_ctrl_chk #(
  parameter int unsigned PTR_W    = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PAGE     = 1,
  parameter int unsigned RESET_SP = 8'hFD
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic              pull_done,
  input logic              busy,
  input logic [PTR_W-1:0]  sp,
  input logic [PTR_W-1:0]  x_out,
  input logic              x_we,
  input logic              flag_n,
  input logic              flag_z,
  input logic              ev_accept
);

  localparam int unsigned PAGE_W = ADDR_W - PTR_W;

  p_reset_sp_r1: assert property (@(posedge clk)
    !rst_n |=> (sp == PTR_W'(RESET_SP)) && !busy && !pull_done && !x_we);

  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> mem_addr[ADDR_W-1:PTR_W] == PAGE_W'(PAGE));

  p_write_at_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[PTR_W-1:0] == sp);

  p_write_then_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == PTR_W'($past(sp) - 1));

  p_read_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> mem_addr[PTR_W-1:0] == PTR_W'(sp + 1));

  p_read_then_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp == PTR_W'($past(sp) + 1));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pull_done |=> !pull_done);

  p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    x_we |-> (flag_z == (x_out == '0)) && (flag_n == x_out[PTR_W-1]));

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !x_we);

  p_accept_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !busy);

endmodule

bind stack_page_ctrl stack_page_ctrl_chk #(
  .PTR_W   (PTR_W),
  .ADDR_W  (ADDR_W),
  .PAGE    (PAGE),
  .RESET_SP(RESET_SP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .pull_done(pull_done),
  .busy     (busy),
  .sp       (sp),
  .x_out    (x_out),
  .x_we     (x_we),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .ev_accept(ev_accept)
);

// File: tb/stack_page_ctrl_tb.sv
module stack_page_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [7:0]  push_byte = 8'h00;
  logic [15:0] push_word = 16'h0000;
  logic [7:0]  x_in = 8'h00;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        mem_re;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] pull_data;
  logic        pull_done;
  logic        busy;
  logic [7:0]  sp;
  logic [7:0]  x_out;
  logic        x_we;
  logic        flag_n;
  logic        flag_z;

  int checks = 0;
  int errors = 0;
  int page_bad = 0;
  bit finished = 1'b0;

  logic [7:0] bmem [256];

  always #4 clk = ~clk;

  stack_page_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .push_byte(push_byte), .push_word(push_word), .x_in(x_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .pull_data(pull_data),
    .pull_done(pull_done), .busy(busy), .sp(sp), .x_out(x_out),
    .x_we(x_we), .flag_n(flag_n), .flag_z(flag_z)
  );

  // synchronous stack memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_we || mem_re) begin
      if (mem_addr[15:8] != 8'h01) page_bad++;
    end
    if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= bmem[mem_addr[7:0]];
  end

  // {op[3:0], data[15:0], expected sp[7:0], expected pulled value[15:0]}
  localparam int NVEC = 16;
  localparam logic [43:0] VEC [NVEC] = '{
    {4'd1, 16'h005A, 8'hFC, 16'h0000},
    {4'd3, 16'h1234, 8'hFA, 16'h0000},
    {4'd4, 16'h0000, 8'hFC, 16'h1234},
    {4'd2, 16'h0000, 8'hFD, 16'h005A},
    {4'd1, 16'h00C3, 8'hFC, 16'h0000},
    {4'd2, 16'h0000, 8'hFD, 16'h00C3},
    {4'd5, 16'h0001, 8'h01, 16'h0000},
    {4'd3, 16'hBEEF, 8'hFF, 16'h0000},   // R9 underflow across 0x00
    {4'd4, 16'h0000, 8'h01, 16'hBEEF},   // R9 overflow back up
    {4'd5, 16'h00FF, 8'hFF, 16'h0000},
    {4'd1, 16'h0077, 8'hFE, 16'h0000},
    {4'd2, 16'h0000, 8'hFF, 16'h0077},
    {4'd2, 16'h0000, 8'h00, 16'h00EF},   // R9 pull from 0xFF wraps to 0x00
    {4'd3, 16'hA55A, 8'hFE, 16'h0000},   // R9 word push split over the wrap
    {4'd4, 16'h0000, 8'h00, 16'hA55A},
    {4'd0, 16'h0033, 8'h00, 16'h0000}    // R10 code 0 does nothing
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  // called at a negedge; returns at the negedge where the command is complete
  task automatic run_cmd(input logic [2:0] op, input logic [15:0] d,
                         output logic [15:0] got, output logic seen);
    cmd_op = op; push_byte = d[7:0]; push_word = d; x_in = d[7:0];
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    seen = 1'b0;
    got = 16'h0000;
    for (int k = 0; k < 8; k++) begin
      if (pull_done) begin seen = 1'b1; got = pull_data; end
      if (!busy && (seen || !(op == 3'd2 || op == 3'd4))) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] got;
    logic        seen;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "sp in reset", 32'(sp), 32'hFD);
    chk("R1", "busy/done/x_we in reset", {29'd0, busy, pull_done, x_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sp after reset", 32'(sp), 32'hFD);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] vop;
      vop = VEC[i][42:40];
      run_cmd(vop, VEC[i][39:24], got, seen);
      chk(op_tag(vop), $sformatf("vector %0d sp", i), 32'(sp), 32'(VEC[i][23:16]));
      if (vop == 3'd2 || vop == 3'd4) begin
        chk(op_tag(vop), $sformatf("vector %0d pulled value", i), 32'(got), 32'(VEC[i][15:0]));
        chk(op_tag(vop), $sformatf("vector %0d done seen", i), 32'(seen), 32'd1);
      end
    end

    // R8 pointer read with zero, then with bit 7 set
    run_cmd(3'd5, 16'h0000, got, seen);
    cmd_op = 3'd6; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8", "x_we after read of 0x00", 32'(x_we), 32'd1);
    chk("R8", "x_out/n/z for 0x00", {22'd0, x_out, flag_n, flag_z}, {22'd0, 8'h00, 1'b0, 1'b1});
    @(negedge clk);
    chk("R8", "x_we one cycle only", 32'(x_we), 32'd0);
    run_cmd(3'd5, 16'h0080, got, seen);
    run_cmd(3'd6, 16'h0000, got, seen);
    chk("R8", "x_out/n/z for 0x80", {22'd0, x_out, flag_n, flag_z}, {22'd0, 8'h80, 1'b1, 1'b0});

    // R4 word push busy window, sp 0x80 -> 0x7E
    cmd_op = 3'd3; push_word = 16'h4321; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R4", "busy on second beat", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R4", "idle and sp after word push", {23'd0, busy, sp}, {23'd0, 1'b0, 8'h7E});

    // R6 exact timing, with R10 requests injected while busy
    cmd_op = 3'd4; cmd_valid = 1'b1;
    @(negedge clk);
    chk("R6", "busy/done cycle 1", {30'd0, busy, pull_done}, {30'd0, 2'b10});
    cmd_op = 3'd5; x_in = 8'h33; cmd_valid = 1'b1;
    @(negedge clk);
    chk("R6", "busy/done cycle 2", {30'd0, busy, pull_done}, {30'd0, 2'b10});
    cmd_op = 3'd6; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6", "busy/done cycle 3", {30'd0, busy, pull_done}, {30'd0, 2'b01});
    chk("R6", "word pulled", 32'(pull_data), 32'h4321);
    chk("R10", "sp ignores load while busy", 32'(sp), 32'h80);
    chk("R10", "x_we stays low while busy", 32'(x_we), 32'd0);
    @(negedge clk);
    chk("R6", "done is one pulse", 32'(pull_done), 32'd0);
    chk("R10", "x_out not rewritten", 32'(x_out), 32'h80);

    // R5 exact timing at sp 0x80
    run_cmd(3'd1, 16'h009C, got, seen);
    cmd_op = 3'd2; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5", "busy/done cycle 1", {30'd0, busy, pull_done}, {30'd0, 2'b10});
    @(negedge clk);
    chk("R5", "done cycle 2", {30'd0, busy, pull_done}, {30'd0, 2'b01});
    chk("R5", "byte pulled, high zero", 32'(pull_data), 32'h009C);
    chk("R5", "sp restored", 32'(sp), 32'h80);

    // R10 code 7 is a no-operation
    run_cmd(3'd7, 16'h0011, got, seen);
    chk("R10", "code 7 leaves sp", 32'(sp), 32'h80);

    // R2 page of every access, R9 included the wrap vectors
    checks++;
    if (page_bad != 0) begin
      errors++;
      $display("FAIL R2 off-page accesses: actual %0d expected 0", page_bad);
    end

    // R1 reset in the middle of a word pull
    cmd_op = 3'd4; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mid-command reset sp", 32'(sp), 32'hFD);
    chk("R1", "mid-command reset busy/done", {30'd0, busy, pull_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sp after release", 32'(sp), 32'hFD);

    finish_run();
  end

endmodule